// File: doc/BRIEF.md
# Gated Control Register File

This block is the 32-bit control and status register bank of one TDC acquisition chip. It sits on a simple word-addressed bus that offers a write strobe and a read strobe. The word index it receives is already local to the chip. The bank holds the chip's run settings: a 48-bit wire mask, pipeline depth, level-2 buffer length, hits per channel and module ID. It also holds three mode bits: VME-driven versus DAQ-driven L2A, test-data source, and output flavour. All of these are driven straight to the acquisition logic.

A write-only test-mode register guards every configuration write and the register-clear command. Outside test mode the settings are frozen. The one exception is the software L2A register, which can be written at any time but only acts while the chip is in VME-L2A mode. The bank also tracks four level-2 buffers. A buffer is marked as holding unprocessed data on L1A and unmarked when an accepted L2A names it. That L2A comes from either software or the DAQ input, depending on the mode.

Word map (index, content):
- 0x00: read-only ID. Bits 31..8 hold a program-name constant, bit 0 holds the chip ID.
- 0x01 and 0x02: wire-mask bits 23..0 and 47..24, in data bits 23..0.
- 0x03: pipeline depth in bits 8..0 and buffer length in bits 21..16.
- 0x04: hits per channel in bits 2..0.
- 0x05: module ID in bits 8..0.
- 0x06: software L2A, write-only, buffer number in bits 1..0.
- 0x07: read-only pending status, bit b for buffer b.
- 0x08: L2A-source mode, write-only, bit 0.
- 0x09: test-data mode, write-only, bit 0.
- 0x0A: output flavour, write-only, bit 0.
- 0x0B: test mode, write-only, bit 0.
- 0x0C: clear command, write-only.

Top module: `tdc_ctrl_regs`

## Requirements
- R1: A synchronous active-low reset clears every setting and mode bit, clears the pending status, and returns operation mode, DAQ-driven L2A, and zero on bus_rdata and l2a_fire.
- R2: Writing 1 in bit 0 to word 0x0B enters test mode and writing 0 leaves it, at any time; the word reads back as zero.
- R3: While test mode is off, writes to words 0x01–0x05 and 0x08–0x0A leave all settings unchanged; writes to unmapped words never change anything.
- R4: Words 0x01 and 0x02 hold wire-mask bits 23..0 and 47..24 from data bits 23..0 and read back as written with bits 31..24 zero; a 1 blocks that wire.
- R5: Word 0x03 holds pipeline depth (bits 8..0) and buffer length (bits 21..16), word 0x04 holds hits per channel (bits 2..0), word 0x05 holds the module ID (bits 8..0); all other bits read as zero.
- R6: Bit 0 of words 0x08, 0x09 and 0x0A sets VME-L2A mode, RAM-sourced test data and new-style output respectively (1) or clears them (0); these words read as zero.
- R7: Word 0x00 reads as the program name in bits 31..8, zeros in bits 7..1 and the chip ID in bit 0; writes to it are ignored.
- R8: A write to word 0x06 is accepted in any test-mode state; in VME-L2A mode it raises l2a_fire for exactly the next cycle, with l2a_fire_buf equal to data bits 1..0; in DAQ mode it does nothing.
- R9: In DAQ mode a daq_l2a_valid pulse raises l2a_fire for the next cycle with its buffer number; in VME-L2A mode the DAQ input is ignored. l2a_fire_buf is zero when l2a_fire is low.
- R10: Pending bit b (word 0x07 bits 3..0) is set the cycle after an L1A for buffer b and cleared the cycle after an accepted L2A for b; an L1A wins when both name the same buffer in the same cycle; writes to 0x07 are ignored.
- R11: A write to word 0x0C in test mode returns all settings and the three mode bits to reset values, but leaves test mode and the pending status unchanged; outside test mode it has no effect.
- R12: bus_rdata shows the addressed word one cycle after bus_rd is high and is zero in a cycle that follows no read; unmapped words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Local word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| l1a_valid | input | 1 | Level-1 accept pulse |
| l1a_buf | input | 2 | Buffer number of the L1A |
| daq_l2a_valid | input | 1 | DAQ-driven level-2 accept pulse |
| daq_l2a_buf | input | 2 | Buffer number of the DAQ L2A |
| test_mode | output | 1 | Test mode (write gate open) |
| vme_l2a_mode | output | 1 | 1: software L2A, 0: DAQ L2A |
| test_data_sel | output | 1 | 1: data from RAM, 0: live inputs |
| xft_new_style | output | 1 | 1: new-style output, 0: old-style |
| wire_mask | output | 48 | Per-wire block mask |
| pipe_depth | output | 9 | Pipeline depth setting |
| l2_len | output | 6 | Level-2 buffer length setting |
| hit_limit | output | 3 | Hits processed per channel |
| module_id | output | 9 | Module ID for the header word |
| l2a_fire | output | 1 | Accepted L2A, one-cycle pulse |
| l2a_fire_buf | output | 2 | Buffer number of the accepted L2A |
| l2_pending | output | 4 | Unprocessed-data flag per buffer |

## Verification
Every registered result appears one clock edge after the cycle that carries its cause. This covers a setting change after a write, the l2a_fire pulse after an accepted L2A, a pending-bit change after an L1A or L2A, and read data after bus_rd. Gating and L2A-source selection use the test-mode and L2A-mode values from before that edge, not the values the same edge writes. The bench holds each stimulus across one rising edge and samples one time unit after it. It advances a behavioural model with the inputs that edge saw, and compares every output against that model in every cycle. Directed checks, placed in the same post-edge slot, confirm the boundary cases: blocked writes, the exempt L2A word, an L1A and an L2A on the same buffer in one cycle, and a clear issued outside test mode.

// File: rtl/tdc_regs_pkg.sv
// Package: word indices and field offsets shared by the register bank,
// its checker and its submodules. Assumes a 32-bit data bus.
package tdc_regs_pkg;
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 32;
    localparam int TIM_LEN_LSB = 16;

    localparam logic [ADDR_W-1:0] A_ID      = 'h00;
    localparam logic [ADDR_W-1:0] A_MASK_LO = 'h01;
    localparam logic [ADDR_W-1:0] A_TIMING  = 'h03;
    localparam logic [ADDR_W-1:0] A_HITS    = 'h04;
    localparam logic [ADDR_W-1:0] A_MODULE  = 'h05;
    localparam logic [ADDR_W-1:0] A_SWL2A   = 'h06;
    localparam logic [ADDR_W-1:0] A_STATUS  = 'h07;
    localparam logic [ADDR_W-1:0] A_L2MODE  = 'h08;
    localparam logic [ADDR_W-1:0] A_TDATA   = 'h09;
    localparam logic [ADDR_W-1:0] A_XFT     = 'h0A;
    localparam logic [ADDR_W-1:0] A_TEST    = 'h0B;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 'h0C;
endpackage

// File: rtl/tdc_reg_decode.sv
// Write decoder: turns a bus write into one strobe per register.
// Configuration strobes and the clear strobe are gated by test mode.
// The test-mode and software-L2A strobes are never gated.
// Assumes mask segment words sit at consecutive indices from A_MASK_LO.
module tdc_reg_decode
    import tdc_regs_pkg::*;
#(
    parameter int NSEG = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              test_mode,
    output logic [NSEG-1:0]   seg_we,
    output logic              timing_we,
    output logic              hits_we,
    output logic              module_we,
    output logic              l2mode_we,
    output logic              tdata_we,
    output logic              xft_we,
    output logic              test_we,
    output logic              clear_stb,
    output logic              swl2a_stb
);
    logic gated;
    assign gated = wr_en && test_mode;

    // One gated strobe per wire-mask segment word.
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign seg_we[g] = gated && (addr == A_MASK_LO + ADDR_W'(g));
    end

    // Decode the remaining registers.
    always_comb begin
        timing_we = 1'b0;
        hits_we   = 1'b0;
        module_we = 1'b0;
        l2mode_we = 1'b0;
        tdata_we  = 1'b0;
        xft_we    = 1'b0;
        clear_stb = 1'b0;
        test_we   = wr_en && (addr == A_TEST);
        swl2a_stb = wr_en && (addr == A_SWL2A);
        if (gated) begin
            case (addr)
                A_TIMING: timing_we = 1'b1;
                A_HITS:   hits_we   = 1'b1;
                A_MODULE: module_we = 1'b1;
                A_L2MODE: l2mode_we = 1'b1;
                A_TDATA:  tdata_we  = 1'b1;
                A_XFT:    xft_we    = 1'b1;
                A_CLEAR:  clear_stb = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/tdc_cfg_store.sv
// Settings storage: the wire-mask segments, timing fields, hit limit,
// module ID, the three mode bits and the test-mode bit.
// The clear strobe (already gated) resets everything except test mode.
// Assumes the strobes are one-hot from the decoder.
module tdc_cfg_store
    import tdc_regs_pkg::*;
#(
    parameter int MASK_W = 48,
    parameter int NSEG   = 2,
    parameter int PIPE_W = 9,
    parameter int LEN_W  = 6,
    parameter int HIT_W  = 3,
    parameter int MID_W  = 9,
    localparam int SEG_W = MASK_W / NSEG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSEG-1:0]   seg_we,
    input  logic              timing_we,
    input  logic              hits_we,
    input  logic              module_we,
    input  logic              l2mode_we,
    input  logic              tdata_we,
    input  logic              xft_we,
    input  logic              test_we,
    input  logic              clear_stb,
    output logic [MASK_W-1:0] mask,
    output logic [PIPE_W-1:0] pipe,
    output logic [LEN_W-1:0]  len,
    output logic [HIT_W-1:0]  hits,
    output logic [MID_W-1:0]  mid,
    output logic              l2_vme,
    output logic              tdata,
    output logic              xft_new,
    output logic              test_mode
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    logic wipe;
    assign wipe = !rst_n || clear_stb;

    logic [SEG_W-1:0] seg_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        // Hold one wire-mask segment.
        always_ff @(posedge clk) begin
            if (wipe)           seg_q[g] <= '0;
            else if (seg_we[g]) seg_q[g] <= wdata[SEG_W-1:0];
        end
        assign mask[g*SEG_W +: SEG_W] = seg_q[g];
    end

    // Hold the pipeline depth and buffer length fields.
    always_ff @(posedge clk) begin
        if (wipe) begin
            pipe <= '0;
            len  <= '0;
        end else if (timing_we) begin
            pipe <= wdata[PIPE_W-1:0];
            len  <= wdata[TIM_LEN_LSB +: LEN_W];
        end
    end

    // Hold the hit limit and module ID.
    always_ff @(posedge clk) begin
        if (wipe) begin
            hits <= '0;
            mid  <= '0;
        end else begin
            if (hits_we)   hits <= wdata[HIT_W-1:0];
            if (module_we) mid  <= wdata[MID_W-1:0];
        end
    end

    // Hold the L2A-source, test-data and output-flavour mode bits.
    always_ff @(posedge clk) begin
        if (wipe) begin
            l2_vme  <= 1'b0;
            tdata   <= 1'b0;
            xft_new <= 1'b0;
        end else begin
            if (l2mode_we) l2_vme  <= wdata[0];
            if (tdata_we)  tdata   <= wdata[0];
            if (xft_we)    xft_new <= wdata[0];
        end
    end

    // Hold test mode; only reset and the test word change it.
    always_ff @(posedge clk) begin
        if (!rst_n)       test_mode <= 1'b0;
        else if (test_we) test_mode <= wdata[0];
    end
endmodule

// File: rtl/tdc_l2_tracker.sv
// Level-2 tracker: picks the L2A source by mode, emits the accepted
// L2A as a one-cycle pulse and keeps a pending flag per buffer.
// An L1A and an L2A for one buffer in one cycle leave the flag set.
module tdc_l2_tracker #(
    parameter int NBUF  = 4,
    localparam int BUF_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vme_mode,
    input  logic             sw_stb,
    input  logic [BUF_W-1:0] sw_buf,
    input  logic             daq_valid,
    input  logic [BUF_W-1:0] daq_buf,
    input  logic             l1a_valid,
    input  logic [BUF_W-1:0] l1a_buf,
    output logic             fire,
    output logic [BUF_W-1:0] fire_buf,
    output logic [NBUF-1:0]  pending
);
    logic             acc;
    logic [BUF_W-1:0] acc_buf;

    // Select the L2A source that the current mode honours.
    always_comb begin
        acc     = vme_mode ? sw_stb : daq_valid;
        acc_buf = vme_mode ? sw_buf : daq_buf;
    end

    // Register the accepted L2A as a pulse with its buffer number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire     <= 1'b0;
            fire_buf <= '0;
        end else begin
            fire     <= acc;
            fire_buf <= acc ? acc_buf : '0;
        end
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        // Set on L1A, clear on accepted L2A, L1A taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pending[b] <= 1'b0;
            else if (l1a_valid && l1a_buf == BUF_W'(b))
                pending[b] <= 1'b1;
            else if (acc && acc_buf == BUF_W'(b))
                pending[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/tdc_read_mux.sv
// Readback: registers the addressed word one cycle after a read strobe
// and drives zero after an idle cycle. Write-only and unmapped words
// read as zero. Assumes SEG_W, PIPE_W and others fit in 32 bits.
module tdc_read_mux
    import tdc_regs_pkg::*;
#(
    parameter int          MASK_W    = 48,
    parameter int          NSEG      = 2,
    parameter int          PIPE_W    = 9,
    parameter int          LEN_W     = 6,
    parameter int          HIT_W     = 3,
    parameter int          MID_W     = 9,
    parameter int          NBUF      = 4,
    parameter logic [23:0] PROG_NAME = 24'h7DC0A2,
    parameter logic        CHIP_ID   = 1'b0,
    localparam int SEG_W = MASK_W / NSEG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] mask,
    input  logic [PIPE_W-1:0] pipe,
    input  logic [LEN_W-1:0]  len,
    input  logic [HIT_W-1:0]  hits,
    input  logic [MID_W-1:0]  mid,
    input  logic [NBUF-1:0]   pending,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] val;

    // Assemble the addressed word from the live state.
    always_comb begin
        val = '0;
        case (addr)
            A_ID:     val = {PROG_NAME, 7'd0, CHIP_ID};
            A_TIMING: begin
                val[PIPE_W-1:0]            = pipe;
                val[TIM_LEN_LSB +: LEN_W]  = len;
            end
            A_HITS:   val[HIT_W-1:0] = hits;
            A_MODULE: val[MID_W-1:0] = mid;
            A_STATUS: val[NBUF-1:0]  = pending;
            default:  ;
        endcase
        for (int i = 0; i < NSEG; i++) begin
            if (addr == A_MASK_LO + ADDR_W'(i))
                val[SEG_W-1:0] = mask[i*SEG_W +: SEG_W];
        end
    end

    // Capture the word on a read, otherwise drive zero.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_en ? val : '0;
    end
endmodule

// File: rtl/tdc_ctrl_regs.sv
// Top: gated control and status register bank for one TDC chip.
// Connects the write decoder, settings store, level-2 tracker and
// readback. Assumes a local word index and single-cycle bus strobes.
module tdc_ctrl_regs
    import tdc_regs_pkg::*;
#(
    parameter int          MASK_W    = 48,
    parameter int          NSEG      = 2,
    parameter int          PIPE_W    = 9,
    parameter int          LEN_W     = 6,
    parameter int          HIT_W     = 3,
    parameter int          MID_W     = 9,
    parameter int          NBUF      = 4,
    parameter logic [23:0] PROG_NAME = 24'h7DC0A2,
    parameter logic        CHIP_ID   = 1'b0,
    localparam int BUF_W = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              l1a_valid,
    input  logic [BUF_W-1:0]  l1a_buf,
    input  logic              daq_l2a_valid,
    input  logic [BUF_W-1:0]  daq_l2a_buf,
    output logic              test_mode,
    output logic              vme_l2a_mode,
    output logic              test_data_sel,
    output logic              xft_new_style,
    output logic [MASK_W-1:0] wire_mask,
    output logic [PIPE_W-1:0] pipe_depth,
    output logic [LEN_W-1:0]  l2_len,
    output logic [HIT_W-1:0]  hit_limit,
    output logic [MID_W-1:0]  module_id,
    output logic              l2a_fire,
    output logic [BUF_W-1:0]  l2a_fire_buf,
    output logic [NBUF-1:0]   l2_pending
);
    logic [NSEG-1:0] seg_we;
    logic timing_we, hits_we, module_we, l2mode_we, tdata_we, xft_we;
    logic test_we, clear_stb, swl2a_stb;

    tdc_reg_decode #(.NSEG(NSEG)) u_dec (
        .wr_en(bus_wr), .addr(bus_addr), .test_mode(test_mode),
        .seg_we(seg_we), .timing_we(timing_we), .hits_we(hits_we),
        .module_we(module_we), .l2mode_we(l2mode_we), .tdata_we(tdata_we),
        .xft_we(xft_we), .test_we(test_we), .clear_stb(clear_stb),
        .swl2a_stb(swl2a_stb)
    );

    tdc_cfg_store #(
        .MASK_W(MASK_W), .NSEG(NSEG), .PIPE_W(PIPE_W), .LEN_W(LEN_W),
        .HIT_W(HIT_W), .MID_W(MID_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
        .seg_we(seg_we), .timing_we(timing_we), .hits_we(hits_we),
        .module_we(module_we), .l2mode_we(l2mode_we), .tdata_we(tdata_we),
        .xft_we(xft_we), .test_we(test_we), .clear_stb(clear_stb),
        .mask(wire_mask), .pipe(pipe_depth), .len(l2_len),
        .hits(hit_limit), .mid(module_id), .l2_vme(vme_l2a_mode),
        .tdata(test_data_sel), .xft_new(xft_new_style), .test_mode(test_mode)
    );

    tdc_l2_tracker #(.NBUF(NBUF)) u_l2 (
        .clk(clk), .rst_n(rst_n), .vme_mode(vme_l2a_mode),
        .sw_stb(swl2a_stb), .sw_buf(bus_wdata[BUF_W-1:0]),
        .daq_valid(daq_l2a_valid), .daq_buf(daq_l2a_buf),
        .l1a_valid(l1a_valid), .l1a_buf(l1a_buf),
        .fire(l2a_fire), .fire_buf(l2a_fire_buf), .pending(l2_pending)
    );

    tdc_read_mux #(
        .MASK_W(MASK_W), .NSEG(NSEG), .PIPE_W(PIPE_W), .LEN_W(LEN_W),
        .HIT_W(HIT_W), .MID_W(MID_W), .NBUF(NBUF),
        .PROG_NAME(PROG_NAME), .CHIP_ID(CHIP_ID)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr(bus_addr),
        .mask(wire_mask), .pipe(pipe_depth), .len(l2_len),
        .hits(hit_limit), .mid(module_id), .pending(l2_pending),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/tdc_ctrl_regs_chk.sv
// Checker: temporal properties of the register bank, bound to the top.
module tdc_ctrl_regs_chk
    import tdc_regs_pkg::*;
#(
    parameter int  MASK_W = 48,
    parameter int  MID_W  = 9,
    parameter int  NBUF   = 4,
    localparam int BUF_W  = $clog2(NBUF)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUF_W-1:0]  sw_buf,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              l1a_valid,
    input logic [BUF_W-1:0]  l1a_buf,
    input logic              test_mode,
    input logic              vme_l2a_mode,
    input logic [MASK_W-1:0] wire_mask,
    input logic [MID_W-1:0]  module_id,
    input logic              l2a_fire,
    input logic [BUF_W-1:0]  l2a_fire_buf,
    input logic [NBUF-1:0]   l2_pending
);
    a_r3_frozen_outside_test: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> ($stable(wire_mask) && $stable(module_id)));

    a_r8_sw_l2a_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SWL2A && vme_l2a_mode)
        |=> (l2a_fire && l2a_fire_buf == $past(sw_buf)));

    a_r9_no_fire_without_sw: assert property (@(posedge clk) disable iff (!rst_n)
        (vme_l2a_mode && !(bus_wr && bus_addr == A_SWL2A)) |=> !l2a_fire);

    a_r10_l1a_marks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        l1a_valid |=> l2_pending[$past(l1a_buf)]);

    a_r12_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
endmodule

bind tdc_ctrl_regs tdc_ctrl_regs_chk #(
    .MASK_W(MASK_W), .MID_W(MID_W), .NBUF(NBUF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .sw_buf(bus_wdata[BUF_W-1:0]),
    .bus_rdata(bus_rdata), .l1a_valid(l1a_valid), .l1a_buf(l1a_buf),
    .test_mode(test_mode), .vme_l2a_mode(vme_l2a_mode),
    .wire_mask(wire_mask), .module_id(module_id), .l2a_fire(l2a_fire),
    .l2a_fire_buf(l2a_fire_buf), .l2_pending(l2_pending)
);

// File: tb/tb_tdc_ctrl_regs.sv
module tb_tdc_ctrl_regs;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 5000;
    localparam logic [31:0] ID_WORD = 32'h7DC0A201;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        l1a_valid = 1'b0, daq_l2a_valid = 1'b0;
    logic [1:0]  l1a_buf = '0, daq_l2a_buf = '0;
    logic        test_mode, vme_l2a_mode, test_data_sel, xft_new_style;
    logic [47:0] wire_mask;
    logic [8:0]  pipe_depth, module_id;
    logic [5:0]  l2_len;
    logic [2:0]  hit_limit;
    logic        l2a_fire;
    logic [1:0]  l2a_fire_buf;
    logic [3:0]  l2_pending;

    tdc_ctrl_regs #(.PROG_NAME(24'h7DC0A2), .CHIP_ID(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .l1a_valid(l1a_valid), .l1a_buf(l1a_buf),
        .daq_l2a_valid(daq_l2a_valid), .daq_l2a_buf(daq_l2a_buf),
        .test_mode(test_mode), .vme_l2a_mode(vme_l2a_mode),
        .test_data_sel(test_data_sel), .xft_new_style(xft_new_style),
        .wire_mask(wire_mask), .pipe_depth(pipe_depth), .l2_len(l2_len),
        .hit_limit(hit_limit), .module_id(module_id), .l2a_fire(l2a_fire),
        .l2a_fire_buf(l2a_fire_buf), .l2_pending(l2_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    // Behavioural reference state.
    bit        m_test, m_vme, m_tdata, m_xft, m_fire;
    bit [47:0] m_mask;
    bit [8:0]  m_pipe, m_mid;
    bit [5:0]  m_len;
    bit [2:0]  m_hits;
    bit [1:0]  m_fbuf;
    bit [3:0]  m_pend;
    bit [31:0] m_rdata;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] ref_word(input bit [4:0] a);
        case (a)
            5'h00: return ID_WORD;
            5'h01: return {8'd0, m_mask[23:0]};
            5'h02: return {8'd0, m_mask[47:24]};
            5'h03: return {10'd0, m_len, 7'd0, m_pipe};
            5'h04: return {29'd0, m_hits};
            5'h05: return {23'd0, m_mid};
            5'h07: return {28'd0, m_pend};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_edge();
        bit acc;
        bit [1:0] abuf;
        bit gate;
        if (!rst_n) begin
            m_test = 0; m_vme = 0; m_tdata = 0; m_xft = 0; m_fire = 0;
            m_mask = '0; m_pipe = '0; m_mid = '0; m_len = '0; m_hits = '0;
            m_fbuf = '0; m_pend = '0; m_rdata = '0;
            return;
        end
        m_rdata = bus_rd ? ref_word(bus_addr) : 32'd0;
        acc  = m_vme ? (bus_wr && bus_addr == 5'h06) : daq_l2a_valid;
        abuf = m_vme ? bus_wdata[1:0] : daq_l2a_buf;
        m_fire = acc;
        m_fbuf = acc ? abuf : 2'd0;
        for (int b = 0; b < 4; b++) begin
            if (l1a_valid && l1a_buf == b[1:0]) m_pend[b] = 1'b1;
            else if (acc && abuf == b[1:0])     m_pend[b] = 1'b0;
        end
        gate = m_test;
        if (bus_wr && bus_addr == 5'h0B) m_test = bus_wdata[0];
        if (bus_wr && gate) begin
            case (bus_addr)
                5'h01: m_mask[23:0]  = bus_wdata[23:0];
                5'h02: m_mask[47:24] = bus_wdata[23:0];
                5'h03: begin m_pipe = bus_wdata[8:0]; m_len = bus_wdata[21:16]; end
                5'h04: m_hits  = bus_wdata[2:0];
                5'h05: m_mid   = bus_wdata[8:0];
                5'h08: m_vme   = bus_wdata[0];
                5'h09: m_tdata = bus_wdata[0];
                5'h0A: m_xft   = bus_wdata[0];
                5'h0C: begin
                    m_vme = 0; m_tdata = 0; m_xft = 0; m_mask = '0;
                    m_pipe = '0; m_len = '0; m_hits = '0; m_mid = '0;
                end
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        check(bus_rdata == m_rdata, "R12", "rdata", bus_rdata, m_rdata);
        check(test_mode == m_test, "R2", "test_mode", test_mode, m_test);
        check(wire_mask == m_mask, "R4", "wire_mask", wire_mask, m_mask);
        check({l2_len, pipe_depth} == {m_len, m_pipe}, "R5", "timing",
              {l2_len, pipe_depth}, {m_len, m_pipe});
        check({hit_limit, module_id} == {m_hits, m_mid}, "R5", "hits/id",
              {hit_limit, module_id}, {m_hits, m_mid});
        check({vme_l2a_mode, test_data_sel, xft_new_style} == {m_vme, m_tdata, m_xft},
              "R6", "modes", {vme_l2a_mode, test_data_sel, xft_new_style},
              {m_vme, m_tdata, m_xft});
        check({l2a_fire, l2a_fire_buf} == {m_fire, m_fbuf}, "R8/R9", "l2a_fire",
              {l2a_fire, l2a_fire_buf}, {m_fire, m_fbuf});
        check(l2_pending == m_pend, "R10", "pending", l2_pending, m_pend);
    endtask

    // One clock: inputs held across the edge, outputs sampled after it.
    task automatic step();
        @(posedge clk);
        #1;
        model_edge();
        compare_all();
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; l1a_valid = 0; daq_l2a_valid = 0;
    endtask

    task automatic wr(input bit [4:0] a, input bit [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        idle();
    endtask

    task automatic rd_expect(input bit [4:0] a, input bit [31:0] exp, input string tag);
        bus_rd = 1; bus_addr = a;
        step();
        check(bus_rdata == exp, tag, "readback", bus_rdata, exp);
        idle();
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        idle();
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset state
        check({test_mode, vme_l2a_mode, test_data_sel, xft_new_style} == 4'b0,
              "R1", "modes after reset",
              {test_mode, vme_l2a_mode, test_data_sel, xft_new_style}, 0);
        check(wire_mask == 0 && l2_pending == 0 && !l2a_fire && bus_rdata == 0,
              "R1", "state after reset", {wire_mask, l2_pending}, 0);

        // R3: writes blocked outside test mode
        wr(5'h01, 32'h00FFFFFF);
        check(wire_mask == 0, "R3", "mask blocked", wire_mask, 0);
        wr(5'h08, 32'h1);
        check(vme_l2a_mode == 0, "R3", "l2 mode blocked", vme_l2a_mode, 0);

        // R2: enter test mode, word reads as zero
        wr(5'h0B, 32'h1);
        check(test_mode == 1, "R2", "test mode entered", test_mode, 1);
        rd_expect(5'h0B, 32'h0, "R2");

        // R4: wire mask halves
        wr(5'h01, 32'hFFABCDEF);
        wr(5'h02, 32'h55123456);
        check(wire_mask == 48'h123456ABCDEF, "R4", "mask", wire_mask, 48'h123456ABCDEF);
        rd_expect(5'h01, 32'h00ABCDEF, "R4");
        rd_expect(5'h02, 32'h00123456, "R4");

        // R5: field positions
        wr(5'h03, 32'hFFFFFFFF);
        rd_expect(5'h03, 32'h003F01FF, "R5");
        wr(5'h04, 32'hFFFFFFFF);
        rd_expect(5'h04, 32'h7, "R5");
        wr(5'h05, 32'h000001A5);
        rd_expect(5'h05, 32'h1A5, "R5");

        // R7: ID word, writes ignored
        rd_expect(5'h00, ID_WORD, "R7");
        wr(5'h00, 32'h0);
        rd_expect(5'h00, ID_WORD, "R7");

        // R12: unmapped reads zero, idle cycle zero
        wr(5'h1F, 32'hFFFFFFFF);
        rd_expect(5'h1F, 32'h0, "R12");
        step();
        check(bus_rdata == 0, "R12", "idle rdata", bus_rdata, 0);

        // R10: L1A marks buffers
        l1a_valid = 1; l1a_buf = 2; step(); l1a_buf = 1; step(); idle();
        check(l2_pending == 4'b0110, "R10", "pending set", l2_pending, 4'b0110);
        // R9: DAQ L2A in DAQ mode
        daq_l2a_valid = 1; daq_l2a_buf = 2; step(); idle();
        check(l2a_fire && l2a_fire_buf == 2, "R9", "daq fire",
              {l2a_fire, l2a_fire_buf}, 3'b110);
        check(l2_pending == 4'b0010, "R9", "daq clear", l2_pending, 4'b0010);
        // R8: software L2A ignored in DAQ mode
        wr(5'h06, 32'h1);
        check(!l2a_fire && l2_pending == 4'b0010, "R8", "sw in daq mode",
              {l2a_fire, l2_pending}, 5'b00010);

        // R6: mode bits
        wr(5'h08, 32'h1);
        wr(5'h09, 32'h1);
        wr(5'h0A, 32'h1);
        check({vme_l2a_mode, test_data_sel, xft_new_style} == 3'b111, "R6", "modes set",
              {vme_l2a_mode, test_data_sel, xft_new_style}, 3'b111);
        rd_expect(5'h08, 32'h0, "R6");

        // R8: software L2A in VME mode
        wr(5'h06, 32'hFFFFFFF1);
        check(l2a_fire && l2a_fire_buf == 1, "R8", "sw fire",
              {l2a_fire, l2a_fire_buf}, 3'b101);
        step();
        check(!l2a_fire, "R8", "single pulse", l2a_fire, 0);
        check(l2_pending == 0, "R8", "sw clear", l2_pending, 0);
        // R9: DAQ ignored in VME mode
        l1a_valid = 1; l1a_buf = 0; step(); idle();
        daq_l2a_valid = 1; daq_l2a_buf = 0; step(); idle();
        check(!l2a_fire && l2_pending == 4'b0001, "R9", "daq ignored",
              {l2a_fire, l2_pending}, 5'b00001);
        // R10: same-cycle L1A and L2A on buffer 3
        l1a_valid = 1; l1a_buf = 3;
        wr(5'h06, 32'h3);
        check(l2a_fire && l2_pending == 4'b1001, "R10", "l1a wins",
              {l2a_fire, l2_pending}, 5'b11001);
        wr(5'h07, 32'h0);
        rd_expect(5'h07, 32'h9, "R10");

        // R8 exemption and R3/R11 outside test mode
        wr(5'h0B, 32'h0);
        wr(5'h06, 32'h3);
        check(l2a_fire && l2_pending == 4'b0001, "R8", "exempt write",
              {l2a_fire, l2_pending}, 5'b10001);
        wr(5'h02, 32'h0);
        check(wire_mask == 48'h123456ABCDEF, "R3", "mask frozen", wire_mask, 48'h123456ABCDEF);
        wr(5'h0C, 32'h0);
        check(module_id == 9'h1A5 && vme_l2a_mode, "R11", "clear blocked",
              {module_id, vme_l2a_mode}, {9'h1A5, 1'b1});

        // R11: clear in test mode
        wr(5'h0B, 32'h1);
        wr(5'h0C, 32'h0);
        check(wire_mask == 0 && module_id == 0 && hit_limit == 0 && pipe_depth == 0,
              "R11", "settings cleared", {wire_mask, module_id}, 0);
        check({test_mode, vme_l2a_mode, test_data_sel, xft_new_style} == 4'b1000,
              "R11", "modes after clear",
              {test_mode, vme_l2a_mode, test_data_sel, xft_new_style}, 4'b1000);
        check(l2_pending == 4'b0001, "R11", "pending kept", l2_pending, 4'b0001);

        repeat (3) step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule